// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block holds one byte of state and steers a single serial data bit into any one of its eight positions, chosen by a 3-bit address. Two active-low controls, an enable and a clear, pick one of four operating modes. In **WRITE** mode the addressed bit is loaded and the rest keep their values. In **HOLD** mode nothing changes. In **DEMUX** mode the outputs act as a one-of-eight demultiplexer. In **CLEAR** mode every output is forced low. Storage is a clocked register that stands in for transparent latches. In DEMUX and CLEAR the outputs are formed combinationally, so the decode path does not wait for a clock edge.

The mode is the block's state selector. It is decoded every cycle from `{en_n, clr_n}`: `01` gives WRITE, `11` gives HOLD, `00` gives DEMUX and `10` gives CLEAR. Every transition between any two modes is allowed and takes effect in the same cycle the controls change. The WRITE→HOLD transition is the one normally used to freeze a written pattern. The DEMUX→HOLD transition keeps the demultiplexed pattern, because DEMUX also loads the register. The CLEAR→any transition starts from an all-zero register.

Address changes are only safe in HOLD mode. A monitor raises a warning flag when the address moves while the enable is active.

Top module: `addr_latch`

## Requirements
- R1: After reset, with the controls in HOLD (`en_n=1`, `clr_n=1`), `q` is all zeros and `addr_hazard` is 0.
- R2: At a clock edge in WRITE mode (`en_n=0`, `clr_n=1`), register bit `addr` takes `din` and all other bits keep their values. The register drives `q` in WRITE and HOLD, so the new value appears on `q` after that edge.
- R3: In HOLD mode (`en_n=1`, `clr_n=1`), `q` stays unchanged whatever `din` and `addr` do.
- R4: In DEMUX mode (`en_n=0`, `clr_n=0`), `q` equals `din` at bit position `addr` and 0 at every other position. This follows the inputs in the same cycle, with no clock edge needed.
- R5: In CLEAR mode (`en_n=1`, `clr_n=0`), `q` is all zeros in the same cycle, whatever `din` and `addr` are. The register is cleared at the next edge, so a later HOLD shows zeros.
- R6: Address value k selects bit k of `q`, with `addr[0]` as the least significant bit. Address 0 selects `q[0]` and address 7 selects `q[7]`.
- R7: A clock edge in DEMUX mode loads the register with the demultiplexed pattern. A switch to HOLD afterwards shows `din` at the addressed bit and zeros elsewhere.
- R8: `addr_hazard` is 1 in the cycle after an edge at which `en_n=0` and `addr` differed from the address sampled at the previous edge. The sampled address is 0 after reset. In all other cases `addr_hazard` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Serial data bit |
| addr | input | 3 | Bit select, LSB is addr[0] |
| en_n | input | 1 | Active-low enable |
| clr_n | input | 1 | Active-low clear |
| q | output | 8 | Parallel outputs |
| addr_hazard | output | 1 | Warning: address moved while enabled |

## Verification
Directed sequences walk every address in DEMUX with `din` high. This separates a correct bit mapping from a reversed or shifted decoder. Back-to-back WRITEs to different bits followed by HOLD show whether a write leaks into neighbouring bits or loses earlier ones. DEMUX→HOLD and CLEAR→HOLD sequences tell a register that copies the combinational pattern apart from one that keeps stale data. Seeded random traffic mixes all four modes and keeps the address fixed most of the time while enabled. This exercises the hazard flag both when it should rise and when it should stay low.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_WRITE = 2'b01,
        MODE_CLEAR = 2'b10,
        MODE_HOLD  = 2'b11
    } latch_mode_e;
endpackage

// File: rtl/latch_mode_decode.sv
module latch_mode_decode
    import addr_latch_pkg::*;
(
    input  logic        en_n,
    input  logic        clr_n,
    output latch_mode_e mode
);
    always_comb begin
        unique case ({en_n, clr_n})
            2'b01:   mode = MODE_WRITE;
            2'b11:   mode = MODE_HOLD;
            2'b00:   mode = MODE_DEMUX;
            default: mode = MODE_CLEAR;
        endcase
    end
endmodule

// File: rtl/latch_addr_decode.sv
module latch_addr_decode #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NBITS-1:0]  sel
);
    for (genvar i = 0; i < NBITS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end
endmodule

// File: rtl/latch_store.sv
module latch_store
    import addr_latch_pkg::*;
#(
    parameter int NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  latch_mode_e      mode,
    input  logic             din,
    input  logic [NBITS-1:0] sel,
    output logic [NBITS-1:0] store
);
    logic [NBITS-1:0] store_nxt;

    always_comb begin
        unique case (mode)
            MODE_CLEAR: store_nxt = '0;
            MODE_DEMUX: store_nxt = sel & {NBITS{din}};
            MODE_WRITE: store_nxt = (store & ~sel) | (sel & {NBITS{din}});
            MODE_HOLD:  store_nxt = store;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) store <= '0;
        else        store <= store_nxt;
    end
endmodule

// File: rtl/addr_change_monitor.sv
module addr_change_monitor #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_hazard
);
    logic [ADDR_W-1:0] addr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_prev   <= '0;
            addr_hazard <= 1'b0;
        end else begin
            addr_prev   <= addr;
            addr_hazard <= !en_n && (addr != addr_prev);
        end
    end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] addr,
    input  logic              en_n,
    input  logic              clr_n,
    output logic [NBITS-1:0]  q,
    output logic              addr_hazard
);
    latch_mode_e      mode;
    logic [NBITS-1:0] sel;
    logic [NBITS-1:0] store;

    latch_mode_decode u_mode (
        .en_n (en_n),
        .clr_n(clr_n),
        .mode (mode)
    );

    latch_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(addr),
        .sel (sel)
    );

    latch_store #(.NBITS(NBITS)) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (mode),
        .din  (din),
        .sel  (sel),
        .store(store)
    );

    addr_change_monitor #(.ADDR_W(ADDR_W)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_n       (en_n),
        .addr       (addr),
        .addr_hazard(addr_hazard)
    );

    always_comb begin
        unique case (mode)
            MODE_CLEAR: q = '0;
            MODE_DEMUX: q = sel & {NBITS{din}};
            MODE_WRITE: q = store;
            MODE_HOLD:  q = store;
        endcase
    end
endmodule

// File: rtl/addr_latch_checker.sv
module addr_latch_checker #(
    parameter int ADDR_W = 3,
    localparam int NBITS = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              din,
    input logic [ADDR_W-1:0] addr,
    input logic              en_n,
    input logic              clr_n,
    input logic [NBITS-1:0]  q,
    input logic              addr_hazard
);
    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!en_n && clr_n) && clr_n) |-> (q[$past(addr)] == $past(din))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en_n && clr_n) && en_n && clr_n) |-> $stable(q)); // R3

    AST_DEMUX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n) |-> ($countones(q) == (din ? 1 : 0))); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |-> (q == '0)); // R5

    AST_DEMUX_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!en_n && !clr_n) && en_n && clr_n)
            |-> (q == (NBITS'($past(din)) << $past(addr)))); // R7

    AST_HAZARD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && addr_hazard) |-> $past(!en_n)); // R8
endmodule

bind addr_latch addr_latch_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .din        (din),
    .addr       (addr),
    .en_n       (en_n),
    .clr_n      (clr_n),
    .q          (q),
    .addr_hazard(addr_hazard)
);

// File: tb/addr_latch_bench.sv
module addr_latch_bench;
    localparam int ADDR_W = 3;
    localparam int NBITS  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              din = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              en_n = 1'b1;
    logic              clr_n = 1'b1;
    logic [NBITS-1:0]  q;
    logic              addr_hazard;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [NBITS-1:0]  m_store = '0;
    logic [ADDR_W-1:0] m_prev  = '0;
    logic              m_haz   = 1'b0;

    always #10 clk = ~clk;

    addr_latch #(.ADDR_W(ADDR_W)) u_addr_latch (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
        .en_n(en_n), .clr_n(clr_n), .q(q), .addr_hazard(addr_hazard)
    );

    function automatic logic [NBITS-1:0] exp_q(logic e, logic c, logic d, logic [ADDR_W-1:0] a,
                                               logic [NBITS-1:0] st);
        case ({e, c})
            2'b00:   return NBITS'(d) << a;
            2'b10:   return '0;
            default: return st;
        endcase
    endfunction

    function automatic logic [NBITS-1:0] next_store(logic e, logic c, logic d, logic [ADDR_W-1:0] a,
                                                    logic [NBITS-1:0] st);
        logic [NBITS-1:0] r;
        r = st;
        case ({e, c})
            2'b00:   r = NBITS'(d) << a;
            2'b10:   r = '0;
            2'b01:   r[a] = d;
            default: r = st;
        endcase
        return r;
    endfunction

    task automatic check_q(string req, logic [NBITS-1:0] exp);
        n_cmp++;
        if (q !== exp) begin
            n_bad++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic check_haz(string req);
        n_cmp++;
        if (addr_hazard !== m_haz) begin
            n_bad++;
            $display("FAIL %s: addr_hazard=%b expected %b", req, addr_hazard, m_haz);
        end
    endtask

    // Drive one cycle, check outputs mid-cycle, then advance the model at the edge.
    task automatic step(string req, logic d, logic [ADDR_W-1:0] a, logic e, logic c);
        @(negedge clk);
        din = d; addr = a; en_n = e; clr_n = c;
        #2;
        check_q(req, exp_q(e, c, d, a, m_store));
        check_haz("R8");
        @(posedge clk);
        m_haz   = !e && (a != m_prev);
        m_prev  = a;
        m_store = next_store(e, c, d, a, m_store);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check_q("R1", '0);
        check_haz("R1");

        // R6: every address in demux maps to its own bit
        for (int k = 0; k < NBITS; k++) step("R6", 1'b1, ADDR_W'(k), 1'b0, 1'b0);
        step("R4", 1'b0, 3'd5, 1'b0, 1'b0);
        // R7: demux edge then hold keeps the pattern
        step("R7", 1'b1, 3'd6, 1'b0, 1'b0);
        step("R7", 1'b0, 3'd6, 1'b1, 1'b1);
        check_q("R7", 8'h40);
        // R5: clear forces zero, then hold shows zero
        step("R5", 1'b1, 3'd6, 1'b1, 1'b0);
        step("R5", 1'b1, 3'd2, 1'b1, 1'b1);
        check_q("R5", 8'h00);
        // R2: back-to-back writes to different bits, then hold
        step("R2", 1'b1, 3'd0, 1'b0, 1'b1);
        step("R2", 1'b1, 3'd7, 1'b0, 1'b1);
        step("R2", 1'b1, 3'd3, 1'b0, 1'b1);
        step("R2", 1'b0, 3'd7, 1'b0, 1'b1);
        step("R3", 1'b1, 3'd1, 1'b1, 1'b1);
        check_q("R2", 8'h09);
        // R3: hold ignores data and address
        for (int k = 0; k < 6; k++) step("R3", k[0], ADDR_W'(k), 1'b1, 1'b1);

        // Random mix of modes; address mostly kept while enabled
        for (int i = 0; i < 3000; i++) begin
            logic e, c, d;
            logic [ADDR_W-1:0] a;
            string req;
            e = 1'($urandom_range(0, 1));
            c = ($urandom_range(0, 3) != 0);
            d = 1'($urandom_range(0, 1));
            a = addr;
            if (e || ($urandom_range(0, 4) == 0)) a = ADDR_W'($urandom_range(0, NBITS - 1));
            case ({e, c})
                2'b01:   req = "R2";
                2'b11:   req = "R3";
                2'b00:   req = "R4";
                default: req = "R5";
            endcase
            step(req, d, a, e, c);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule